// File: doc/BRIEF.md
# Multi-Polynomial Checksum Engine

This block folds a stream of 8-, 16- or 32-bit data writes into a running cyclic redundancy remainder. A control input chooses one of three generator polynomials: a 16-bit one (0x8005), a 16-bit CCITT one (0x1021) or a 32-bit one (0x04C11DB7). Software loads a starting remainder through a seed port. It then writes data and reads the checksum, which is a combinational view of the remainder.

Two independent three-bit controls shape the data path. One applies bit reversal, byte reversal and inversion to each incoming write. The other applies the same three operations to the checksum shown at the output. Together they cover the reflected and the non-reflected variants of common checksums. The engine absorbs one byte per clock: a byte write completes at once, and wider writes raise `busy` until their remaining bytes have been folded in.

Top module: `crc_engine`

## Requirements
- R1: `poly_sel` 0 selects polynomial 0x8005 (16-bit), 1 selects 0x1021 (16-bit), and 2 or 3 selects 0x04C11DB7 (32-bit). Each data bit updates the remainder MSB-first and non-reflected: the feedback is remainder MSB XOR data bit, then shift left and XOR the polynomial when the feedback is 1.
- R2: A `seed_load` pulse sets the remainder to `seed_val` on the next edge. It takes priority over any write, aborts a multi-byte absorb in progress, and leaves `busy` low afterwards.
- R3: `wr_size` 0 writes `wr_data[7:0]`, 1 writes `wr_data[15:0]`, and 2 or 3 writes all 32 bits. After the data transform, bytes are folded least significant first, and the bits of each byte are folded MSB first.
- R4: A byte write completes on its accepting edge and never raises `busy`. A half-word write holds `busy` high for 1 cycle after acceptance, and a word write holds it high for 3 cycles. `busy` never stays high for more than 3 consecutive cycles.
- R5: A write presented while `busy` is high is ignored and changes neither the remainder nor the absorb in progress. The writer must hold it until `busy` falls.
- R6: `data_xf` applies to the written bytes only. Bit 0 reverses the bits within each byte, bit 1 reverses the byte order within the write width, and bit 2 inverts every written bit.
- R7: `result_xf` applies to `crc_out` only and never to the stored remainder. Bit 0 reverses all bits of the active width (16 or 32), bit 1 reverses the byte order within that width, and bit 2 inverts that width.
- R8: With a 16-bit polynomial, only `seed_val[15:0]` is used, and `crc_out[31:16]` is always zero.
- R9: After reset the remainder is zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poly_sel | input | 2 | Polynomial select |
| data_xf | input | 3 | Input transform: bit0 bit reverse, bit1 byte reverse, bit2 invert |
| result_xf | input | 3 | Output transform: bit0 bit reverse, bit1 byte reverse, bit2 invert |
| seed_load | input | 1 | Load the seed into the remainder |
| seed_val | input | 32 | Seed value |
| wr_en | input | 1 | Data write strobe |
| wr_size | input | 2 | Write size: 0 byte, 1 half-word, 2/3 word |
| wr_data | input | 32 | Write data |
| busy | output | 1 | High while the remaining bytes of a write are being folded in |
| crc_out | output | 32 | Transformed checksum |

## Verification
The hardest situations to reach are the ones inside the three-cycle window of a word absorb. A second write can collide with the stalled bytes there, or a seed load can cut the absorb short. The bench first accepts a word write, then acts on the first falling edge at which `busy` is seen high. In one test it holds a conflicting write across that edge. In another it pulses `seed_load` there. The final checksum, or the seed read back at the output, shows whether the pending bytes were kept or discarded. Known catalogue check values over the string "123456789" give fixed expectations for the reflected and non-reflected variants. The same string is also split into half-words, words, byte-reversed words and pre-inverted bytes, and each split must reach the same value.

// File: rtl/crc_pkg.sv
package crc_pkg;

   localparam logic [15:0] POLY_A16 = 16'h8005;
   localparam logic [15:0] POLY_B16 = 16'h1021;
   localparam logic [31:0] POLY_C32 = 32'h04C11DB7;

   typedef enum logic [1:0] {
      SEL_A16  = 2'd0,
      SEL_B16  = 2'd1,
      SEL_C32  = 2'd2,
      SEL_C32B = 2'd3
   } poly_sel_e;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_WORDB = 2'd3
   } wr_size_e;

   typedef struct packed {
      logic invert;
      logic swap_bytes;
      logic flip_bits;
   } xform_t;

   function automatic logic [7:0] flip8(input logic [7:0] b);
      logic [7:0] r;
      for (int k = 0; k < 8; k++) r[k] = b[7-k];
      return r;
   endfunction

endpackage

// File: rtl/crc_in_xform.sv
module crc_in_xform
   import crc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [1:0]        size_i,
   input  logic [2:0]        xf_i,
   output logic [DATA_W-1:0] data_o
);
   localparam int unsigned NB = DATA_W / 8;

   xform_t xf;
   assign xf = xform_t'(xf_i);

   logic [7:0] bytes_a [NB];
   int         nb;

   always_comb begin
      case (size_i)
         SZ_BYTE: nb = 1;
         SZ_HALF: nb = 2;
         default: nb = int'(NB);
      endcase
      for (int i = 0; i < int'(NB); i++) begin
         bytes_a[i] = xf.flip_bits ? flip8(data_i[8*i +: 8]) : data_i[8*i +: 8];
      end
      data_o = '0;
      for (int i = 0; i < int'(NB); i++) begin
         if (i < nb) begin
            data_o[8*i +: 8] = (xf.swap_bytes ? bytes_a[nb-1-i] : bytes_a[i])
                               ^ {8{xf.invert}};
         end
      end
   end
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
   parameter int unsigned   W    = 32,
   parameter logic [W-1:0]  POLY = '0
) (
   input  logic [W-1:0] rem_i,
   input  logic [7:0]   byte_i,
   output logic [W-1:0] rem_o
);
   always_comb begin
      rem_o = rem_i;
      for (int k = 0; k < 8; k++) begin
         if (rem_o[W-1] ^ byte_i[7-k]) rem_o = (rem_o << 1) ^ POLY;
         else                          rem_o = rem_o << 1;
      end
   end
endmodule

// File: rtl/crc_out_xform.sv
module crc_out_xform
   import crc_pkg::*;
#(
   parameter int unsigned REM_W = 32
) (
   input  logic [REM_W-1:0] rem_i,
   input  logic             narrow_i,
   input  logic [2:0]       xf_i,
   output logic [REM_W-1:0] crc_o
);
   localparam int unsigned HALF_W = REM_W / 2;

   xform_t xf;
   assign xf = xform_t'(xf_i);

   logic [REM_W-1:0] flipped, swapped;
   int               w, nbo;

   always_comb begin
      w   = narrow_i ? int'(HALF_W) : int'(REM_W);
      nbo = w / 8;
      flipped = '0;
      for (int k = 0; k < int'(REM_W); k++) begin
         if (k < w) flipped[k] = xf.flip_bits ? rem_i[w-1-k] : rem_i[k];
      end
      swapped = '0;
      for (int i = 0; i < int'(REM_W / 8); i++) begin
         if (i < nbo) swapped[8*i +: 8] = xf.swap_bytes ? flipped[8*(nbo-1-i) +: 8]
                                                        : flipped[8*i +: 8];
      end
      crc_o = '0;
      for (int k = 0; k < int'(REM_W); k++) begin
         if (k < w) crc_o[k] = swapped[k] ^ xf.invert;
      end
   end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
   import crc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        poly_sel,
   input  logic [2:0]        data_xf,
   input  logic [2:0]        result_xf,
   input  logic              seed_load,
   input  logic [DATA_W-1:0] seed_val,
   input  logic              wr_en,
   input  logic [1:0]        wr_size,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic [DATA_W-1:0] crc_out
);
   localparam int unsigned NB     = DATA_W / 8;
   localparam int unsigned CNT_W  = $clog2(NB);
   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned NPOLY  = 3;

   initial begin
      assert (DATA_W == 32) else $error("crc_engine: DATA_W must be 32");
   end

   logic [DATA_W-1:0]   rem_q;
   logic [DATA_W-9:0]   pend_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [DATA_W-1:0]   xdata;
   logic [7:0]          cur_byte;
   logic                accept, narrow;
   logic [CNT_W-1:0]    extra;
   logic [DATA_W-1:0]   step_res [NPOLY];
   logic [DATA_W-1:0]   step_sel;

   assign busy   = (cnt_q != '0);
   assign accept = wr_en && !busy && !seed_load;
   assign narrow = (poly_sel == SEL_A16) || (poly_sel == SEL_B16);

   crc_in_xform #(.DATA_W(DATA_W)) u_in (
      .data_i (wr_data),
      .size_i (wr_size),
      .xf_i   (data_xf),
      .data_o (xdata)
   );

   assign cur_byte = busy ? pend_q[7:0] : xdata[7:0];

   for (genvar g = 0; g < int'(NPOLY); g++) begin : g_step
      if (g == int'(NPOLY) - 1) begin : g_wide
         crc_byte_step #(.W(DATA_W), .POLY(POLY_C32)) u_step (
            .rem_i  (rem_q),
            .byte_i (cur_byte),
            .rem_o  (step_res[g])
         );
      end else begin : g_narrow
         logic [HALF_W-1:0] r16;
         crc_byte_step #(.W(HALF_W), .POLY((g == 0) ? POLY_A16 : POLY_B16)) u_step (
            .rem_i  (rem_q[HALF_W-1:0]),
            .byte_i (cur_byte),
            .rem_o  (r16)
         );
         assign step_res[g] = {{(DATA_W-HALF_W){1'b0}}, r16};
      end
   end

   always_comb begin
      case (poly_sel)
         SEL_A16: step_sel = step_res[0];
         SEL_B16: step_sel = step_res[1];
         default: step_sel = step_res[2];
      endcase
      case (wr_size)
         SZ_BYTE: extra = CNT_W'(0);
         SZ_HALF: extra = CNT_W'(1);
         default: extra = CNT_W'(NB - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         pend_q <= '0;
         cnt_q  <= '0;
      end else if (seed_load) begin
         rem_q  <= narrow ? {{(DATA_W-HALF_W){1'b0}}, seed_val[HALF_W-1:0]} : seed_val;
         pend_q <= '0;
         cnt_q  <= '0;
      end else if (busy) begin
         rem_q  <= step_sel;
         pend_q <= pend_q >> 8;
         cnt_q  <= cnt_q - 1'b1;
      end else if (accept) begin
         rem_q  <= step_sel;
         pend_q <= xdata[DATA_W-1:8];
         cnt_q  <= extra;
      end
   end

   crc_out_xform #(.REM_W(DATA_W)) u_out (
      .rem_i    (rem_q),
      .narrow_i (narrow),
      .xf_i     (result_xf),
      .crc_o    (crc_out)
   );

   logic [3:0] busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else           busy_run <= '0;
   end

   p_seed_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> !busy);

   p_byte_quick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && !seed_load && wr_size == SZ_BYTE) |=> !busy);

   p_word_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && !seed_load && wr_size[1]) |=> busy);

   p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run < 4'(NB));

   p_stall_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !seed_load) |=> (cnt_q == $past(cnt_q) - 1'b1));

   p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      narrow |-> (crc_out[DATA_W-1:HALF_W] == '0));

endmodule

// File: tb/crc_engine_tb.sv
module crc_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  poly_sel = 2'd2;
   logic [2:0]  data_xf = 3'd0;
   logic [2:0]  result_xf = 3'd0;
   logic        seed_load = 1'b0;
   logic [31:0] seed_val = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_size = 2'd0;
   logic [31:0] wr_data = '0;
   logic        busy;
   logic [31:0] crc_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   crc_engine u_dut (
      .clk(clk), .rst_n(rst_n), .poly_sel(poly_sel), .data_xf(data_xf),
      .result_xf(result_xf), .seed_load(seed_load), .seed_val(seed_val),
      .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
      .busy(busy), .crc_out(crc_out)
   );

   typedef struct packed {
      logic [1:0]  poly;
      logic [2:0]  dxf;
      logic [2:0]  rxf;
      logic [31:0] seed;
      logic [31:0] expv;
   } vec_t;

   // Catalogue check values over "123456789"
   localparam vec_t VECS [10] = '{
      '{2'd2, 3'd0, 3'd0, 32'hFFFFFFFF, 32'h0376E6E7},
      '{2'd2, 3'd1, 3'd5, 32'hFFFFFFFF, 32'hCBF43926},
      '{2'd0, 3'd1, 3'd1, 32'h00000000, 32'h0000BB3D},
      '{2'd0, 3'd0, 3'd0, 32'h00000000, 32'h0000FEE8},
      '{2'd1, 3'd0, 3'd0, 32'hFFFFFFFF, 32'h000029B1},
      '{2'd1, 3'd0, 3'd0, 32'h00000000, 32'h000031C3},
      '{2'd1, 3'd1, 3'd1, 32'h00000000, 32'h00002189},
      '{2'd2, 3'd0, 3'd2, 32'hFFFFFFFF, 32'hE7E67603},
      '{2'd1, 3'd0, 3'd4, 32'hFFFFFFFF, 32'h0000D64E},
      '{2'd2, 3'd0, 3'd4, 32'hFFFFFFFF, 32'hFC891918}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual %08h expected %08h", req, act, expv);
      end
   endtask

   task automatic do_seed(input logic [31:0] v);
      seed_val  = v;
      seed_load = 1'b1;
      @(negedge clk);
      seed_load = 1'b0;
   endtask

   task automatic do_write(input logic [1:0] sz, input logic [31:0] d, output int nbusy);
      while (busy) @(negedge clk);
      wr_en = 1'b1; wr_size = sz; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      nbusy = 0;
      while (busy) begin
         nbusy++;
         @(negedge clk);
      end
   endtask

   task automatic feed_string();
      int nb;
      for (int c = 0; c < 9; c++) do_write(2'd0, 32'h31 + 32'(c), nb);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int nb;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 reset busy", {31'd0, busy}, 32'd0);
      chk("R9 reset remainder", crc_out, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R6 R7 R8: table of catalogue variants
      for (int v = 0; v < 10; v++) begin
         poly_sel  = VECS[v].poly;
         data_xf   = VECS[v].dxf;
         result_xf = VECS[v].rxf;
         do_seed(VECS[v].seed);
         feed_string();
         chk($sformatf("R1 R6 R7 R8 table %0d", v), crc_out, VECS[v].expv);
      end

      poly_sel = 2'd2; data_xf = 3'd0; result_xf = 3'd0;

      // R2: seed visible at output
      do_seed(32'hFFFFFFFF);
      chk("R2 seed visible", crc_out, 32'hFFFFFFFF);

      // R3 R4: word writes, LSB byte first
      do_write(2'd2, 32'h34333231, nb);
      chk("R4 word busy cycles", 32'(nb), 32'd3);
      do_write(2'd2, 32'h38373635, nb);
      do_write(2'd0, 32'hFFFFFF39, nb);
      chk("R4 byte busy cycles", 32'(nb), 32'd0);
      chk("R3 word split", crc_out, 32'h0376E6E7);

      // R3 R4: half-word writes
      do_seed(32'hFFFFFFFF);
      do_write(2'd1, 32'hFFFF3231, nb);
      chk("R4 half busy cycles", 32'(nb), 32'd1);
      do_write(2'd1, 32'h00003433, nb);
      do_write(2'd1, 32'h00003635, nb);
      do_write(2'd1, 32'h00003837, nb);
      do_write(2'd0, 32'h00000039, nb);
      chk("R3 half split", crc_out, 32'h0376E6E7);

      // R6: byte reverse of data
      data_xf = 3'd2;
      do_seed(32'hFFFFFFFF);
      do_write(2'd2, 32'h31323334, nb);
      do_write(2'd2, 32'h35363738, nb);
      do_write(2'd0, 32'h00000039, nb);
      chk("R6 data byte reverse", crc_out, 32'h0376E6E7);

      // R6: inversion of data
      data_xf = 3'd4;
      do_seed(32'hFFFFFFFF);
      for (int c = 0; c < 9; c++) do_write(2'd0, ~(32'h31 + 32'(c)), nb);
      chk("R6 data invert", crc_out, 32'h0376E6E7);
      data_xf = 3'd0;

      // R5: write presented while busy is ignored
      do_seed(32'hFFFFFFFF);
      wr_en = 1'b1; wr_size = 2'd2; wr_data = 32'h34333231;
      @(negedge clk);
      chk("R5 busy after word accept", {31'd0, busy}, 32'd1);
      wr_data = 32'hDEADBEEF;
      @(negedge clk);
      wr_en = 1'b0;
      while (busy) @(negedge clk);
      do_write(2'd2, 32'h38373635, nb);
      do_write(2'd0, 32'h00000039, nb);
      chk("R5 stalled write ignored", crc_out, 32'h0376E6E7);

      // R2: seed load aborts an absorb in progress
      do_seed(32'hFFFFFFFF);
      wr_en = 1'b1; wr_size = 2'd2; wr_data = 32'hA5A5A5A5;
      @(negedge clk);
      wr_en = 1'b0;
      do_seed(32'h12345678);
      chk("R2 abort busy low", {31'd0, busy}, 32'd0);
      chk("R2 abort seed", crc_out, 32'h12345678);
      repeat (4) @(negedge clk);
      chk("R2 abort no residue", crc_out, 32'h12345678);

      // R8: upper seed bits dropped in 16-bit mode
      poly_sel = 2'd1;
      do_seed(32'hABCD1234);
      chk("R8 narrow seed", crc_out, 32'h00001234);

      // R7: result transform does not touch stored remainder
      result_xf = 3'd7;
      @(negedge clk);
      result_xf = 3'd0;
      @(negedge clk);
      chk("R7 remainder untouched", crc_out, 32'h00001234);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule